// File: doc/BRIEF.md
# Two-Queue Credit-Based Bandwidth Shaper

This block paces transmission on the first two transmit queues of a port. Each shaped queue holds a credit counter in offset-binary form, where the midpoint `0x8000_0000` stands for zero credit. Credit grows at a programmed idle slope while a frame waits, and falls at a fixed send slope while the queue transmits. It is clamped between a programmed high-credit ceiling and a fixed low-credit floor. A queue may start a frame only while its credit is zero or above. Queues with a higher index have no shaper and are always eligible.

Software programs each shaped queue with one write. The write carries an enable bit, a keep-credits bit, an idle-slope code and a high-credit value. The high-credit value is in the same offset-binary scale as the credit. An idle-slope code of 1 is about 40.96 kb/s of reserved bandwidth. The send slope and the low-credit floor are fixed by parameters and cannot be programmed. Credit changes only on cycles where the time tick input is high. The scheduler around the block reads the eligible flags, and a read port returns the credit of any queue.

Top module: `cbs_shaper`

## Requirements
- R1: After reset, every queue reads credit `0x8000_0000` (zero), and every queue is eligible.
- R2: On a tick, an enabled shaped queue with a pending frame that is not transmitting gains its idle-slope code in credit. The result is clamped to a ceiling equal to the larger of its high-credit value and `0x8000_0000`.
- R3: On a tick, an enabled shaped queue that is transmitting loses `SEND_SLOPE` in credit, and never drops below `LO_CREDIT`. Transmitting takes precedence over pending.
- R4: A shaped queue's eligible flag is 1 exactly when its credit is at least `0x8000_0000`.
- R5: A disabled shaped queue has its slope and ceiling cleared and its credit held at `0x8000_0000`, whatever its pending and transmit inputs are, so it stays eligible.
- R6: On a tick, an enabled shaped queue that is empty and not transmitting, with keep-credits clear and credit above `0x8000_0000`, has its credit set to `0x8000_0000`.
- R7: On a tick, an enabled shaped queue that is empty and not transmitting keeps credit above zero unchanged when keep-credits is set. A negative credit rises by the idle slope, clamped at `0x8000_0000`, whatever keep-credits is.
- R8: A configuration write to queue 0 or 1 loads its settings and sets its credit to `0x8000_0000`. A write to queue 2 or above has no effect, and those queues always read `0x8000_0000` and are eligible.
- R9: Without a tick or a configuration write, no credit changes.
- R10: `rd_credit_o` shows the credit of the queue picked by `rd_sel_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Credit update strobe |
| pending_i | input | NUM_Q | Per-queue frame waiting |
| xmit_i | input | NUM_Q | Per-queue frame on the wire |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_q_i | input | QW | Queue addressed by the write |
| cfg_en_i | input | 1 | Shaper enable |
| cfg_keep_i | input | 1 | Keep positive credit while empty |
| cfg_slope_i | input | SLOPE_W | Idle-slope code |
| cfg_hicred_i | input | CRED_W | Offset-binary high-credit ceiling |
| rd_sel_i | input | QW | Queue whose credit is read |
| rd_credit_o | output | CRED_W | Offset-binary credit of the selected queue |
| eligible_o | output | NUM_Q | Per-queue eligible flag |

## Verification
The assertions check four things on every cycle:
- Credit never falls below the floor.
- A waiting tick never lowers credit, and a transmitting tick never raises it.
- An empty tick never leaves credit higher than before unless the result is at most zero.
- A queue loses eligibility only after a transmitting tick.

The exact clamp values, the reset to zero on empty with keep-credits clear, the effect of disabling a queue, and ignored writes to unshaped queues need the bench's directed scenarios. The bench's random traffic with a reference model covers the same behaviour.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   // Offset-binary zero for a credit of width w
   function automatic logic [63:0] zero_mid(input int w);
      return 64'd1 << (w - 1);
   endfunction
endpackage

// File: rtl/cbs_credit_unit.sv
module cbs_credit_unit #(
   parameter int CRED_W = 32,
   parameter int SLOPE_W = 16,
   parameter logic [CRED_W-1:0] SEND_SLOPE = 32'h0002_0000,
   parameter logic [CRED_W-1:0] LO_CREDIT = 32'h7FF8_0000
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               tick_i,
   input  logic               pend_i,
   input  logic               xmit_i,
   input  logic               wr_i,
   input  logic               en_i,
   input  logic               keep_i,
   input  logic [SLOPE_W-1:0] slope_i,
   input  logic [CRED_W-1:0]  hicred_i,
   output logic [CRED_W-1:0]  cred_o,
   output logic               elig_o
);
   localparam logic [CRED_W-1:0] ZERO_C = CRED_W'(cbs_pkg::zero_mid(CRED_W));
   localparam logic [CRED_W:0] FLOOR_SUM = {1'b0, LO_CREDIT} + {1'b0, SEND_SLOPE};

   logic               en_q, keep_q;
   logic [SLOPE_W-1:0] slope_q;
   logic [CRED_W-1:0]  hic_q, cred_q, cred_d, ceil_c;
   logic [CRED_W:0]    sum_c;

   always_comb begin
      ceil_c = (hic_q > ZERO_C) ? hic_q : ZERO_C;
      sum_c  = {1'b0, cred_q} + {{(CRED_W+1-SLOPE_W){1'b0}}, slope_q};
      cred_d = cred_q;
      if (!en_q) begin
         cred_d = ZERO_C;
      end else if (xmit_i) begin
         cred_d = ({1'b0, cred_q} < FLOOR_SUM) ? LO_CREDIT : cred_q - SEND_SLOPE;
      end else if (pend_i) begin
         cred_d = (sum_c > {1'b0, ceil_c}) ? ceil_c : sum_c[CRED_W-1:0];
      end else if (cred_q > ZERO_C) begin
         cred_d = keep_q ? cred_q : ZERO_C;
      end else begin
         cred_d = (sum_c > {1'b0, ZERO_C}) ? ZERO_C : sum_c[CRED_W-1:0];
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_q    <= 1'b0;
         keep_q  <= 1'b0;
         slope_q <= '0;
         hic_q   <= '0;
         cred_q  <= ZERO_C;
      end else if (wr_i) begin
         en_q    <= en_i;
         keep_q  <= keep_i;
         slope_q <= en_i ? slope_i : '0;
         hic_q   <= en_i ? hicred_i : '0;
         cred_q  <= ZERO_C;
      end else if (tick_i) begin
         cred_q  <= cred_d;
      end
   end

   assign cred_o = cred_q;
   assign elig_o = (cred_q >= ZERO_C);
endmodule

// File: rtl/cbs_rd_mux.sv
module cbs_rd_mux #(
   parameter int NUM_Q = 4,
   parameter int CRED_W = 32,
   localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic [NUM_Q-1:0][CRED_W-1:0] cred_i,
   input  logic [QW-1:0]                sel_i,
   output logic [CRED_W-1:0]            cred_o
);
   always_comb begin
      cred_o = cred_i[0];
      for (int q = 1; q < NUM_Q; q++) begin
         if (sel_i == QW'(q)) cred_o = cred_i[q];
      end
   end
endmodule

// File: rtl/cbs_shaper.sv
module cbs_shaper #(
   parameter int NUM_Q = 4,
   parameter int NUM_SHAPED = 2,
   parameter int CRED_W = 32,
   parameter int SLOPE_W = 16,
   parameter logic [CRED_W-1:0] SEND_SLOPE = 32'h0002_0000,
   parameter logic [CRED_W-1:0] LO_CREDIT = 32'h7FF8_0000,
   localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               tick_i,
   input  logic [NUM_Q-1:0]   pending_i,
   input  logic [NUM_Q-1:0]   xmit_i,
   input  logic               cfg_we_i,
   input  logic [QW-1:0]      cfg_q_i,
   input  logic               cfg_en_i,
   input  logic               cfg_keep_i,
   input  logic [SLOPE_W-1:0] cfg_slope_i,
   input  logic [CRED_W-1:0]  cfg_hicred_i,
   input  logic [QW-1:0]      rd_sel_i,
   output logic [CRED_W-1:0]  rd_credit_o,
   output logic [NUM_Q-1:0]   eligible_o
);
   localparam logic [CRED_W-1:0] ZERO_C = CRED_W'(cbs_pkg::zero_mid(CRED_W));

   if (NUM_SHAPED < 1 || NUM_SHAPED > NUM_Q) begin : g_bad_shaped
      $error("NUM_SHAPED must lie in 1..NUM_Q");
   end
   if (SLOPE_W >= CRED_W) begin : g_bad_slope
      $error("SLOPE_W must be narrower than CRED_W");
   end
   if (LO_CREDIT >= ZERO_C || SEND_SLOPE == '0) begin : g_bad_limits
      $error("LO_CREDIT must be negative and SEND_SLOPE nonzero");
   end

   logic [NUM_Q-1:0][CRED_W-1:0] cred_all;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      if (q < NUM_SHAPED) begin : g_shaped
         cbs_credit_unit #(
            .CRED_W(CRED_W), .SLOPE_W(SLOPE_W),
            .SEND_SLOPE(SEND_SLOPE), .LO_CREDIT(LO_CREDIT)
         ) u_unit (
            .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i),
            .pend_i(pending_i[q]), .xmit_i(xmit_i[q]),
            .wr_i(cfg_we_i && (cfg_q_i == QW'(q))),
            .en_i(cfg_en_i), .keep_i(cfg_keep_i),
            .slope_i(cfg_slope_i), .hicred_i(cfg_hicred_i),
            .cred_o(cred_all[q]), .elig_o(eligible_o[q])
         );
      end else begin : g_plain
         assign cred_all[q]   = ZERO_C;
         assign eligible_o[q] = 1'b1;
      end
   end

   cbs_rd_mux #(.NUM_Q(NUM_Q), .CRED_W(CRED_W)) u_rd (
      .cred_i(cred_all), .sel_i(rd_sel_i), .cred_o(rd_credit_o)
   );
endmodule

// File: rtl/cbs_shaper_chk.sv
module cbs_shaper_chk #(
   parameter int NUM_Q = 4,
   parameter int NUM_SHAPED = 2,
   parameter int CRED_W = 32,
   parameter logic [CRED_W-1:0] LO_CREDIT = 32'h7FF8_0000
) (
   input logic                          clk_i,
   input logic                          rst_i,
   input logic                          tick_i,
   input logic [NUM_Q-1:0]              pending_i,
   input logic [NUM_Q-1:0]              xmit_i,
   input logic                          cfg_we_i,
   input logic [NUM_Q-1:0]              eligible_o,
   input logic [NUM_Q-1:0][CRED_W-1:0]  cred_all
);
   localparam logic [CRED_W-1:0] ZERO_C = CRED_W'(cbs_pkg::zero_mid(CRED_W));

   for (genvar q = 0; q < NUM_SHAPED; q++) begin : g_a
      // R3: floor never crossed
      p_floor_r3: assert property (@(posedge clk_i) disable iff (rst_i)
         cred_all[q] >= LO_CREDIT);
      // R3: a transmitting tick never raises credit
      p_xmit_down_r3: assert property (@(posedge clk_i) disable iff (rst_i)
         (tick_i && xmit_i[q] && !cfg_we_i) |=> (cred_all[q] <= $past(cred_all[q])));
      // R2: a waiting tick never lowers credit
      p_wait_up_r2: assert property (@(posedge clk_i) disable iff (rst_i)
         (tick_i && pending_i[q] && !xmit_i[q] && !cfg_we_i)
            |=> (cred_all[q] >= $past(cred_all[q])));
      // R6: an empty tick raises credit only up to zero
      p_empty_cap_r6: assert property (@(posedge clk_i) disable iff (rst_i)
         (tick_i && !pending_i[q] && !xmit_i[q] && !cfg_we_i)
            |=> (cred_all[q] <= $past(cred_all[q]) || cred_all[q] <= ZERO_C));
      // R4: eligibility is lost only through a transmitting tick
      p_elig_fall_r4: assert property (@(posedge clk_i) disable iff (rst_i)
         $fell(eligible_o[q]) |-> $past(tick_i && xmit_i[q]));
      // R9: no tick and no write means no change
      p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
         (!tick_i && !cfg_we_i) |=> $stable(cred_all[q]));
   end
endmodule

bind cbs_shaper cbs_shaper_chk #(
   .NUM_Q(NUM_Q), .NUM_SHAPED(NUM_SHAPED), .CRED_W(CRED_W), .LO_CREDIT(LO_CREDIT)
) u_chk (
   .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .pending_i(pending_i),
   .xmit_i(xmit_i), .cfg_we_i(cfg_we_i), .eligible_o(eligible_o),
   .cred_all(cred_all)
);

// File: tb/sim_cbs_shaper.sv
module sim_cbs_shaper;
   localparam int CLK_PERIOD = 10;
   localparam int NQ = 4;
   localparam int NS = 2;
   localparam int QW = 2;
   localparam logic [31:0] ZERO = 32'h8000_0000;
   localparam logic [31:0] SEND = 32'h0002_0000;
   localparam logic [31:0] LO = 32'h7FF8_0000;

   logic clk = 1'b0;
   logic rst_i, tick_i, cfg_we_i, cfg_en_i, cfg_keep_i;
   logic [NQ-1:0] pending_i, xmit_i, eligible_o;
   logic [QW-1:0] cfg_q_i, rd_sel_i;
   logic [15:0] cfg_slope_i;
   logic [31:0] cfg_hicred_i, rd_credit_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic        m_en[NS], m_keep[NS];
   logic [15:0] m_slope[NS];
   logic [31:0] m_hic[NS], m_cred[NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   cbs_shaper u0 (
      .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .pending_i(pending_i),
      .xmit_i(xmit_i), .cfg_we_i(cfg_we_i), .cfg_q_i(cfg_q_i), .cfg_en_i(cfg_en_i),
      .cfg_keep_i(cfg_keep_i), .cfg_slope_i(cfg_slope_i), .cfg_hicred_i(cfg_hicred_i),
      .rd_sel_i(rd_sel_i), .rd_credit_o(rd_credit_o), .eligible_o(eligible_o)
   );

   function automatic logic [31:0] f_next(int q, logic pd, logic xm);
      longint c = m_cred[q];
      longint ceil_v = (m_hic[q] > ZERO) ? m_hic[q] : ZERO;
      if (!m_en[q]) return ZERO;
      if (xm) return (c - SEND < LO) ? LO : 32'(c - SEND);
      if (pd) return (c + m_slope[q] > ceil_v) ? 32'(ceil_v) : 32'(c + m_slope[q]);
      if (c > ZERO) return m_keep[q] ? 32'(c) : ZERO;
      return (c + m_slope[q] > ZERO) ? ZERO : 32'(c + m_slope[q]);
   endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string r, int q);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s q%0d: actual %h expected %h", r, q, act, exp);
      end
   endtask

   task automatic check_all(string r);
      for (int q = 0; q < NQ; q++) begin
         logic [31:0] ec = (q < NS) ? m_cred[q] : ZERO;
         rd_sel_i = QW'(q);
         #1;
         chk(rd_credit_o, ec, r, q);
         chk(32'(eligible_o[q]), 32'(ec >= ZERO), {r, "/R4"}, q);
      end
   endtask

   task automatic step(logic tk, logic [NQ-1:0] pd, logic [NQ-1:0] xm, string r);
      tick_i = tk; pending_i = pd; xmit_i = xm; cfg_we_i = 1'b0;
      if (tk) for (int q = 0; q < NS; q++) m_cred[q] = f_next(q, pd[q], xm[q]);
      @(negedge clk);
      check_all(r);
   endtask

   task automatic cfg(int q, logic en, logic kp, logic [15:0] sl, logic [31:0] hc, string r);
      tick_i = $urandom_range(0, 1); pending_i = '1; xmit_i = '1;
      cfg_we_i = 1'b1; cfg_q_i = QW'(q); cfg_en_i = en; cfg_keep_i = kp;
      cfg_slope_i = sl; cfg_hicred_i = hc;
      for (int k = 0; k < NS; k++) begin
         if (k == q) begin
            m_en[k] = en; m_keep[k] = kp;
            m_slope[k] = en ? sl : 16'h0; m_hic[k] = en ? hc : 32'h0;
            m_cred[k] = ZERO;
         end else if (tick_i) begin
            m_cred[k] = f_next(k, 1'b1, 1'b1);
         end
      end
      @(negedge clk);
      cfg_we_i = 1'b0;
      check_all(r);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_i = 1'b1; tick_i = 0; pending_i = '0; xmit_i = '0; cfg_we_i = 0;
      cfg_q_i = '0; cfg_en_i = 0; cfg_keep_i = 0; cfg_slope_i = '0; cfg_hicred_i = '0;
      rd_sel_i = '0;
      for (int q = 0; q < NS; q++) begin
         m_en[q] = 0; m_keep[q] = 0; m_slope[q] = 0; m_hic[q] = 0; m_cred[q] = ZERO;
      end
      repeat (3) @(negedge clk);
      rst_i = 1'b0;
      check_all("R1");

      // R2 rise and ceiling clamp, R9 hold
      cfg(0, 1, 0, 16'h1000, ZERO + 32'h3000, "R8");
      for (int i = 0; i < 4; i++) step(1, 4'b0001, 4'b0000, "R2");
      for (int i = 0; i < 3; i++) step(0, 4'b0001, 4'b0001, "R9");
      // R6 positive credit dropped when empty, keep clear
      step(1, 4'b0000, 4'b0000, "R6");
      // R3 fall to floor, precedence over pending
      for (int i = 0; i < 6; i++) step(1, 4'b0001, 4'b0001, "R3");
      // R7 negative credit recovers to zero and stops
      for (int i = 0; i < 132; i++) step(1, 4'b0000, 4'b0000, "R7");
      // R7 keep-credits holds positive credit
      cfg(1, 1, 1, 16'h0800, ZERO + 32'h5000, "R8");
      for (int i = 0; i < 3; i++) step(1, 4'b0010, 4'b0000, "R2");
      for (int i = 0; i < 3; i++) step(1, 4'b0000, 4'b0000, "R7");
      // R5 disabled queue stays at zero under traffic
      cfg(1, 0, 0, 16'hFFFF, 32'hFFFF_FFFF, "R5");
      for (int i = 0; i < 4; i++) step(1, 4'b0010, 4'b0010, "R5");
      // R8 writes to unshaped queues ignored
      cfg(2, 1, 0, 16'h0001, 32'h0, "R8");
      cfg(3, 1, 1, 16'h0001, 32'h0, "R8");
      for (int i = 0; i < 3; i++) step(1, 4'b1100, 4'b1100, "R8");

      // Random traffic with occasional reconfiguration, R10 read back
      for (int i = 0; i < 2000; i++) begin
         if ($urandom_range(0, 40) == 0)
            cfg($urandom_range(0, 3), ($urandom_range(0, 4) != 0), $urandom_range(0, 1),
                16'($urandom_range(0, 16'h4000)),
                ZERO + 32'($urandom_range(0, 32'h0004_0000)) - 32'h0000_8000, "R10");
         else
            step(($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom & $urandom), "R10");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule